// File: doc/BRIEF.md
# I2C Master Bit Engine with Bus Recovery

This block is the bit-level half of an I2C master. A transaction sequencer sits above it and hands it one command at a time. The engine then moves the two bus lines through the sequence for that command. The commands are bus recovery, START, STOP, byte write and byte read. When a byte write ends, the engine returns the acknowledge bit it sampled. When a byte read ends, it returns the received byte, and it has already sent the acknowledge level the sequencer asked for. The engine never drives a line high. Each line has one enable output: asserting the enable pulls the line low, and deasserting it lets the external pull-up raise the line.

All timing comes from one delay unit. A unit is `divisor + 1` clock cycles, and `divisor` is a run-time input. Every command is a fixed list of units, and the SCL high time of each data and acknowledge bit is two units. The recovery command first releases both lines. It then clocks SCL nine times with SDA released, so that a target stuck in mid-byte can finish, and it closes with a STOP.

The received SDA level passes through a two-flop synchronizer before it is used. `ready` is high while the engine is idle. `done` pulses for one cycle as a command completes.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, and both `sclOe` and `sdaOe` are 0, so both lines are released.
- R2: A command is taken only in a cycle where `cmdValid` and `ready` are both high and `cmdOp` holds a defined code: 0 bus recovery, 1 START, 2 STOP, 3 write, 4 read. Codes 5 to 7, and any `cmdValid` that arrives while the engine is busy, are ignored.
- R3: One unit lasts `divisor + 1` clock cycles. After a command is taken, `ready` stays low for exactly N units: N is 4 for START, 4 for STOP, 37 for write, 29 for read and 40 for recovery. `done` is high for one cycle only, in the first cycle that `ready` is high again.
- R4: A line is pulled low only while its enable output is 1. While the engine is idle, neither enable output changes.
- R5: START releases SDA, then releases SCL, then pulls SDA low while SCL is high. It ends with SCL released and SDA pulled low.
- R6: STOP pulls SCL low, then SDA low, then releases SCL, then releases SDA while SCL is high. It ends with both lines released.
- R7: A write shifts `cmdData` out MSB first. SDA changes only while SCL is low, and SCL stays released for two units for each bit.
- R8: On the ninth SCL pulse of a write, the engine releases SDA and samples it at the end of the high time. The sampled value appears on `ackBit`: 0 means ACK and 1 means NACK.
- R9: A read samples eight bits MSB first, one unit after each SCL rise, with SDA released. The result appears on `rxData` when the command completes.
- R10: On the ninth SCL pulse of a read, the engine drives SDA to `cmdAck`: 0 pulls the line low (ACK) and 1 releases it (NACK).
- R11: Recovery releases both lines, then gives nine SCL pulses with SDA released, each pulse two units low and two units high, and then a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clocks per unit minus one |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 3 | Command code: 0 recovery, 1 START, 2 STOP, 3 write, 4 read |
| cmdData | input | DATA_W | Byte to write |
| cmdAck | input | 1 | Acknowledge level to send after a read (0 ACK, 1 NACK) |
| sdaIn | input | 1 | Raw SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| ready | output | 1 | Idle; a command can be taken |
| done | output | 1 | One-cycle pulse when a command completes |
| rxData | output | DATA_W | Last byte read |
| ackBit | output | 1 | Acknowledge sampled after the last write |

## Verification
The assertions check every cycle that `done` appears only alongside `ready` and lasts one cycle, and that an idle engine stays idle and keeps both enables still when no valid command arrives. They also check that, while a write is running, SDA changes only while SCL is held low. The bench scenarios cover what the assertions cannot see: the exact busy length in units for each command and each divisor, the bit order on the bus, the acknowledge in both directions, the START and STOP edges, the nine recovery pulses, and the two-unit SCL high time. A simple target model on the bench side answers on SDA to supply these cases.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  localparam logic [2:0] OP_MAX = 3'd4;

  typedef enum logic [1:0] {
    SCL_KEEP,
    SCL_LOW,
    SCL_REL
  } sclAct_e;

  typedef enum logic [2:0] {
    SDA_KEEP,
    SDA_LOW,
    SDA_REL,
    SDA_TX,
    SDA_ACK
  } sdaAct_e;

  typedef struct packed {
    logic    releaseAll;
    logic    loadCmd;
    sclAct_e sclAct;
    sdaAct_e sdaAct;
    logic    shiftTx;
    logic    sampleRx;
    logic    sampleAck;
  } strobe_t;

endpackage

// File: rtl/i2c_unit_timer.sv
module i2c_unit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] count;

  assign tick = run && (count >= divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (!run || tick) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/i2c_bit_ctrl.sv
module i2c_bit_ctrl
  import i2c_bit_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int RECOVER_PULSES = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       tick,
  output logic       ready,
  output logic       done,
  output strobe_t    strobe
);

  localparam int MAX_COUNT = (DATA_W > RECOVER_PULSES) ? DATA_W : RECOVER_PULSES;
  localparam int CNT_W     = $clog2(MAX_COUNT);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(RECOVER_PULSES - 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_STOP,
    ST_WBIT,
    ST_WACK,
    ST_RBIT,
    ST_RACK,
    ST_PULSE
  } state_e;

  state_e           state;
  logic [2:0]       phase;
  logic [2:0]       lastPhase;
  logic [CNT_W-1:0] bitCnt;
  logic             accept;
  logic             unitEnd;
  logic             lastUnit;

  assign ready   = (state == ST_IDLE);
  assign accept  = cmdValid && ready && (cmdOp <= OP_MAX);
  assign unitEnd = tick && (phase == lastPhase);

  always_comb begin
    case (state)
      ST_WACK, ST_RACK: lastPhase = 3'd4;
      ST_RBIT:          lastPhase = 3'd2;
      default:          lastPhase = 3'd3;
    endcase
  end

  always_comb begin
    case (state)
      ST_START, ST_STOP, ST_WACK, ST_RACK: lastUnit = unitEnd;
      default:                             lastUnit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= lastUnit;
      if (accept) begin
        phase  <= '0;
        bitCnt <= '0;
        case (op_e'(cmdOp))
          OP_RECOVER: state <= ST_PULSE;
          OP_START:   state <= ST_START;
          OP_STOP:    state <= ST_STOP;
          OP_WRITE:   state <= ST_WBIT;
          default:    state <= ST_RBIT;
        endcase
      end else if (tick) begin
        if (!unitEnd) begin
          phase <= phase + 1'b1;
        end else begin
          phase <= '0;
          case (state)
            ST_WBIT: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) begin
                state  <= ST_WACK;
                bitCnt <= '0;
              end
            end
            ST_RBIT: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) begin
                state  <= ST_RACK;
                bitCnt <= '0;
              end
            end
            ST_PULSE: begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_PULSE) begin
                state  <= ST_STOP;
                bitCnt <= '0;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // Line levels held for the current unit, plus sample and shift strobes at its end
  always_comb begin
    strobe            = '0;
    strobe.sclAct     = SCL_KEEP;
    strobe.sdaAct     = SDA_KEEP;
    strobe.loadCmd    = accept;
    strobe.releaseAll = accept && (cmdOp == OP_RECOVER);
    case (state)
      ST_START: begin
        case (phase)
          3'd0:    ;
          3'd1:    strobe.sdaAct = SDA_REL;
          3'd2:    begin strobe.sclAct = SCL_REL; strobe.sdaAct = SDA_REL; end
          default: begin strobe.sclAct = SCL_REL; strobe.sdaAct = SDA_LOW; end
        endcase
      end
      ST_STOP: begin
        case (phase)
          3'd0:    strobe.sclAct = SCL_LOW;
          3'd1:    begin strobe.sclAct = SCL_LOW; strobe.sdaAct = SDA_LOW; end
          3'd2:    begin strobe.sclAct = SCL_REL; strobe.sdaAct = SDA_LOW; end
          default: begin strobe.sclAct = SCL_REL; strobe.sdaAct = SDA_REL; end
        endcase
      end
      ST_WBIT: begin
        case (phase)
          3'd0:    strobe.sclAct = SCL_LOW;
          3'd1:    begin strobe.sclAct = SCL_LOW; strobe.sdaAct = SDA_TX; end
          default: begin strobe.sclAct = SCL_REL; strobe.sdaAct = SDA_TX; end
        endcase
        strobe.shiftTx = unitEnd;
      end
      ST_WACK: begin
        case (phase)
          3'd0:       strobe.sclAct = SCL_LOW;
          3'd2, 3'd3: begin strobe.sclAct = SCL_REL; strobe.sdaAct = SDA_REL; end
          default:    begin strobe.sclAct = SCL_LOW; strobe.sdaAct = SDA_REL; end
        endcase
        strobe.sampleAck = tick && (phase == 3'd3);
      end
      ST_RBIT: begin
        strobe.sdaAct   = SDA_REL;
        strobe.sclAct   = (phase == 3'd0) ? SCL_LOW : SCL_REL;
        strobe.sampleRx = tick && (phase == 3'd1);
      end
      ST_RACK: begin
        case (phase)
          3'd0:       strobe.sclAct = SCL_LOW;
          3'd2, 3'd3: begin strobe.sclAct = SCL_REL; strobe.sdaAct = SDA_ACK; end
          default:    begin strobe.sclAct = SCL_LOW; strobe.sdaAct = SDA_ACK; end
        endcase
      end
      ST_PULSE: begin
        strobe.sdaAct = SDA_REL;
        strobe.sclAct = (phase < 3'd2) ? SCL_LOW : SCL_REL;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/i2c_bit_datapath.sv
module i2c_bit_datapath
  import i2c_bit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdAck,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              ackBit
);

  logic              sclRel;
  logic              sdaRel;
  logic [1:0]        sdaSync;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              ackLevel;
  logic              ackSample;

  assign sclOe  = !sclRel;
  assign sdaOe  = !sdaRel;
  assign rxData = rxShift;
  assign ackBit = ackSample;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaSync <= 2'b11;
    end else begin
      sdaSync <= {sdaSync[0], sdaIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclRel <= 1'b1;
      sdaRel <= 1'b1;
    end else if (strobe.releaseAll) begin
      sclRel <= 1'b1;
      sdaRel <= 1'b1;
    end else begin
      case (strobe.sclAct)
        SCL_LOW: sclRel <= 1'b0;
        SCL_REL: sclRel <= 1'b1;
        default: ;
      endcase
      case (strobe.sdaAct)
        SDA_LOW: sdaRel <= 1'b0;
        SDA_REL: sdaRel <= 1'b1;
        SDA_TX:  sdaRel <= txShift[DATA_W-1];
        SDA_ACK: sdaRel <= ackLevel;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      ackLevel  <= 1'b1;
      ackSample <= 1'b0;
    end else begin
      if (strobe.loadCmd) begin
        txShift  <= cmdData;
        ackLevel <= cmdAck;
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strobe.sampleRx) begin
        rxShift <= {rxShift[DATA_W-2:0], sdaSync[1]};
      end
      if (strobe.sampleAck) begin
        ackSample <= sdaSync[1];
      end
    end
  end

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int DIV_W          = 16,
  parameter int DATA_W         = 8,
  parameter int RECOVER_PULSES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              cmdAck,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rxData,
  output logic              ackBit
);

  strobe_t strobe;
  logic    tick;

  i2c_unit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .run     (!ready),
    .divisor (divisor),
    .tick    (tick)
  );

  i2c_bit_ctrl #(.DATA_W(DATA_W), .RECOVER_PULSES(RECOVER_PULSES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .tick     (tick),
    .ready    (ready),
    .done     (done),
    .strobe   (strobe)
  );

  i2c_bit_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdData (cmdData),
    .cmdAck  (cmdAck),
    .sdaIn   (sdaIn),
    .sclOe   (sclOe),
    .sdaOe   (sdaOe),
    .rxData  (rxData),
    .ackBit  (ackBit)
  );

endmodule

// File: rtl/i2c_bit_engine_checker.sv
module i2c_bit_engine_checker
  import i2c_bit_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       ready,
  input logic       done
);

  logic [2:0] opNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opNow <= OP_STOP;
    end else if (cmdValid && ready) begin
      opNow <= cmdOp;
    end
  end

  assert_done_with_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready);

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !cmdValid) |=> ready);

  assert_bad_op_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && cmdValid && (cmdOp > OP_MAX)) |=> ready);

  assert_idle_lines_still_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready)) |-> ($stable(sclOe) && $stable(sdaOe)));

  assert_write_sda_scl_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && (opNow == OP_WRITE) && !$stable(sdaOe)) |-> (sclOe && $past(sclOe)));

endmodule

bind i2c_bit_engine i2c_bit_engine_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .sclOe    (sclOe),
  .sdaOe    (sdaOe),
  .ready    (ready),
  .done     (done)
);

// File: tb/sim_i2c_bit_engine.sv
`timescale 1ns/1ps
module sim_i2c_bit_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = 16'd3;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [7:0]  cmdData = 8'h00;
  logic        cmdAck = 1'b1;
  logic        sclOe, sdaOe, ready, done, ackBit;
  logic [7:0]  rxData;
  logic        slavePull = 1'b0;
  logic        sdaLine;

  assign sdaLine = !(sdaOe || slavePull);

  i2c_bit_engine u0 (
    .clk(clk), .rstN(rstN), .divisor(divisor), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdData(cmdData), .cmdAck(cmdAck), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .ready(ready), .done(done),
    .rxData(rxData), .ackBit(ackBit)
  );

  always #5 clk = !clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Bus monitor and target model
  int          riseCount, startSeen, stopSeen, highCnt, lastHigh;
  logic [15:0] rxLog;
  logic        prevScl = 1'b1, prevSda = 1'b1;
  int          slaveMode = 0;
  logic [7:0]  slaveByte = 8'h00;
  int          busyCnt;
  logic        doneAtEnd, doneAfter;

  always @(negedge clk) begin
    logic sclNow, sdaNow;
    sclNow = !sclOe;
    sdaNow = sdaLine;
    if (sclNow && !prevScl) begin
      riseCount++;
      rxLog   = {rxLog[14:0], sdaNow};
      highCnt = 1;
    end else if (sclNow) begin
      highCnt++;
    end
    if (!sclNow && prevScl) lastHigh = highCnt;
    if (sclNow && prevScl && prevSda && !sdaNow) startSeen++;
    if (sclNow && prevScl && !prevSda && sdaNow) stopSeen++;
    if (!sclNow) begin
      case (slaveMode)
        1: slavePull = (riseCount == 8);
        2: slavePull = (riseCount < 8) ? !slaveByte[7-riseCount] : 1'b0;
        default: slavePull = 1'b0;
      endcase
    end
    prevScl = sclNow;
    prevSda = sdaLine;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [7:0] data,
                        input logic ackL, input bit interfere);
    @(posedge clk);
    riseCount = 0; rxLog = '0; startSeen = 0; stopSeen = 0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = data; cmdAck = ackL;
    @(negedge clk);
    cmdValid = 1'b0;
    busyCnt = 0;
    while (!ready) begin
      busyCnt++;
      if (interfere && busyCnt == 5) begin
        cmdValid = 1'b1; cmdOp = 3'd4; cmdData = 8'h00;
      end else begin
        cmdValid = 1'b0;
      end
      @(negedge clk);
    end
    cmdValid = 1'b0;
    doneAtEnd = done;
    @(negedge clk);
    doneAfter = done;
  endtask

  task automatic checkBusy(input int units, input string tag);
    int exp;
    exp = units * (int'(divisor) + 1);
    check(busyCnt == exp, tag, busyCnt, exp);
    check(doneAtEnd === 1'b1 && doneAfter === 1'b0, {tag, " done pulse"},
          {doneAtEnd, doneAfter}, 2'b10);
  endtask

  task automatic testReset();
    check(ready === 1'b1 && done === 1'b0, "R1 ready/done", {ready, done}, 2'b10);
    check(sclOe === 1'b0 && sdaOe === 1'b0, "R1 lines released", {sclOe, sdaOe}, 0);
  endtask

  task automatic testRecover();
    slaveMode = 0;
    runCmd(3'd0, 8'h00, 1'b1, 1'b0);
    checkBusy(40, "R3 recover length");
    check(riseCount == 10, "R11 pulse count", riseCount, 10);
    check(rxLog[9:1] == 9'h1FF, "R11 SDA released on pulses", rxLog[9:1], 9'h1FF);
    check(stopSeen == 1, "R11 closing stop", stopSeen, 1);
    check(sclOe === 1'b0 && sdaOe === 1'b0, "R6 released after recover", {sclOe, sdaOe}, 0);
  endtask

  task automatic testStart();
    slaveMode = 0;
    runCmd(3'd1, 8'h00, 1'b1, 1'b0);
    checkBusy(4, "R3 start length");
    check(startSeen == 1, "R5 start edge", startSeen, 1);
    check(sclOe === 1'b0 && sdaOe === 1'b1, "R5 end state", {sclOe, sdaOe}, 2'b01);
  endtask

  task automatic testStop();
    slaveMode = 0;
    runCmd(3'd2, 8'h00, 1'b1, 1'b0);
    checkBusy(4, "R3 stop length");
    check(stopSeen == 1, "R6 stop edge", stopSeen, 1);
    check(sclOe === 1'b0 && sdaOe === 1'b0, "R6 end state", {sclOe, sdaOe}, 0);
  endtask

  task automatic testWrite(input logic [7:0] data, input bit targetAck, input bit interfere);
    slaveMode = targetAck ? 1 : 0;
    runCmd(3'd3, data, 1'b1, interfere);
    slaveMode = 0;
    checkBusy(37, interfere ? "R2 busy command ignored" : "R3 write length");
    check(riseCount == 9, "R7 write pulses", riseCount, 9);
    check(rxLog[8:1] == data, "R7 write bits MSB first", rxLog[8:1], data);
    check(ackBit === !targetAck, "R8 ack sampled", ackBit, !targetAck);
    check(lastHigh == 2 * (int'(divisor) + 1), "R7 SCL high two units",
          lastHigh, 2 * (int'(divisor) + 1));
  endtask

  task automatic testRead(input logic [7:0] data, input logic ackL);
    slaveMode = 2; slaveByte = data;
    runCmd(3'd4, 8'h00, ackL, 1'b0);
    slaveMode = 0;
    checkBusy(29, "R3 read length");
    check(rxData === data, "R9 read byte", rxData, data);
    check(riseCount == 9, "R9 read pulses", riseCount, 9);
    check(rxLog[0] === ackL, "R10 master ack level", rxLog[0], ackL);
  endtask

  task automatic testBadOp();
    logic s, d;
    s = sclOe; d = sdaOe;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd7;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check(ready === 1'b1 && done === 1'b0, "R2 bad code ignored", {ready, done}, 2'b10);
      check(sclOe === s && sdaOe === d, "R4 idle lines hold", {sclOe, sdaOe}, {s, d});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testRecover();
    testStart();
    testWrite(8'hA5, 1'b1, 1'b0);
    testWrite(8'h3C, 1'b0, 1'b0);
    testRead(8'h96, 1'b0);
    testRead(8'h5A, 1'b1);
    testStop();
    testBadOp();
    testStart();
    testWrite(8'h81, 1'b1, 1'b1);
    testStop();
    divisor = 16'd7;
    testStart();
    testWrite(8'hC3, 1'b1, 1'b0);
    testRead(8'h3E, 1'b1);
    testStop();
    summary();
  end

endmodule